// File: doc/BRIEF.md
# DMA Transfer Queue Controller

This block is the register front end of a single-channel DMA engine. Software uses a 32-bit register bus to program a destination address, a source address and a length. It then submits the request. The controller gives every accepted request a 3-bit transfer tag and holds up to four requests in order. It passes them, one at a time, to a separate transfer engine over a valid/ready request port. The engine reports each finished tag on a completion port.

Before it submits, software reads the tag that the next request will get. It keeps that tag and later tests the matching bit of the completion bitmap. The submit register reads back busy while a submission waits for a free queue slot. While it reads busy, more submissions are refused. Two interrupt events, a slot freeing and a transfer completing, are latched into a pending register. That register is cleared by writing ones to it. A mask register selects which pending events drive the interrupt line. A control register enables the channel or pauses it. Writing the control register with enable low aborts everything.

Top module: `dmaq_ctrl`

## Requirements
- R1: After reset: control reads 0, mask reads 3 (both events masked), pending reads 0, next tag reads 0, done bitmap reads 0, submit reads 0, `irq_o` and `xreq_valid_o` are low.
- R2: Writing 1 to the submit register (0x408) while enabled queues a request carrying the tag read from 0x404 and the current destination (0x410), source (0x414) and length (0x418) values. Tags increment modulo 8.
- R3: The queue holds 4 requests. A submission made while it is full leaves 0x408 reading 1 until a slot frees, and then it enters the queue. A submit write while 0x408 reads 1 is ignored. The waiting request keeps the parameters it was submitted with.
- R4: Requests leave in submission order, one at a time. `xreq_valid_o` is asserted only when no transfer is in flight. It holds with a stable tag until `xreq_ready_i`.
- R5: Register 0x42c reads the tag of the request most recently handed to the engine.
- R6: A completion on `xdone_valid_i`/`xdone_id_i` sets bit `id` of the done bitmap at 0x428. Queuing a new request with that tag clears the bit.
- R7: Pending register 0x84 bit 0 is set on every handoff (slot freed) and bit 1 on every completion, whatever the mask. Writing ones to 0x84 clears those bits.
- R8: Mask register 0x80 uses bit 0 for the slot-freed event and bit 1 for the completion event, with 1 meaning masked. 0x88 reads pending AND NOT mask, and `irq_o` is the OR of that value.
- R9: With control bit 1 (pause) set, no new request is handed out. A transfer already in flight still completes.
- R10: A write of 0 to control bit 0 at 0x400 flushes the queue, drops a waiting submission, ends the in-flight state and pulses `abort_o` for one cycle. Submit writes while disabled are ignored and allocate no tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Write when high, read when low |
| reg_addr_i | input | 12 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt line |
| xreq_valid_o | output | 1 | Request offered to the engine |
| xreq_ready_i | input | 1 | Engine accepts the request |
| xreq_id_o | output | 3 | Tag of the offered request |
| xreq_dst_o | output | 32 | Destination address |
| xreq_src_o | output | 32 | Source address |
| xreq_len_o | output | 24 | Transfer length |
| xdone_valid_i | input | 1 | Completion strobe |
| xdone_id_i | input | 3 | Tag of the completed transfer |
| abort_o | output | 1 | One-cycle pulse when the channel is disabled |

## Verification
The assertions assume the following about the inputs. The engine reports only tags it has been given. A register access addresses a single register. A completion never arrives for a tag in the same cycle that tag is being re-queued. The bench plays the engine itself. It sends completions only for the tag it has just seen handed out. It keeps `xreq_ready_i` steady while a pause or abort is in progress. It drives all inputs one nanosecond after the rising edge, which keeps every access to one register per cycle.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam logic [11:0] OFS_MASK    = 12'h080;
  localparam logic [11:0] OFS_PEND    = 12'h084;
  localparam logic [11:0] OFS_SOURCE  = 12'h088;
  localparam logic [11:0] OFS_CTRL    = 12'h400;
  localparam logic [11:0] OFS_NEXT_ID = 12'h404;
  localparam logic [11:0] OFS_SUBMIT  = 12'h408;
  localparam logic [11:0] OFS_DST     = 12'h410;
  localparam logic [11:0] OFS_SRC     = 12'h414;
  localparam logic [11:0] OFS_LEN     = 12'h418;
  localparam logic [11:0] OFS_DONE    = 12'h428;
  localparam logic [11:0] OFS_ACTIVE  = 12'h42c;

  localparam int unsigned EV_N    = 2;
  localparam int unsigned EV_SLOT = 0;
  localparam int unsigned EV_DONE = 1;
endpackage

// File: rtl/dmaq_fifo.sv
module dmaq_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= data_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i) |-> !full_o); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !flush_i) |-> !empty_o); // R4
endmodule

// File: rtl/dmaq_ids.sv
module dmaq_ids #(
  parameter int unsigned ID_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic               done_valid_i,
  input  logic [ID_W-1:0]    done_id_i,
  output logic [ID_W-1:0]    next_id_o,
  output logic [2**ID_W-1:0] done_map_o
);
  localparam int unsigned NID = 2 ** ID_W;

  logic [ID_W-1:0] next_q;
  logic [NID-1:0]  map_q;

  assign next_id_o  = next_q;
  assign done_map_o = map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) next_q <= '0;
    else if (alloc_i) next_q <= next_q + ID_W'(1);
  end

  for (genvar i = 0; i < NID; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) map_q[i] <= 1'b0;
      else if (alloc_i && next_q == ID_W'(i)) map_q[i] <= 1'b0;
      else if (done_valid_i && done_id_i == ID_W'(i)) map_q[i] <= 1'b1;
    end
  end

  AST_ID_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> (next_id_o == $past(next_id_o) + ID_W'(1))); // R2
  AST_DONE_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_valid_i && !(alloc_i && next_id_o == done_id_i)) |=> done_map_o[$past(done_id_i)]); // R6
  AST_REISSUE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> !done_map_o[$past(next_id_o)]); // R6
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] src_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (mask_wr_i) mask_q <= mask_i;
      pend_q <= (pend_q & ~(clr_wr_i ? clr_i : '0)) | set_i;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign src_o  = pend_q & ~mask_q;
  assign irq_o  = |src_o;

  AST_EVENT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i))); // R7
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && ((clr_i & set_i) == '0)) |=> ((pend_o & $past(clr_i)) == '0)); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '1) |-> !irq_o); // R8
endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl #(
  parameter int unsigned ID_W  = 3,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned LW    = 24,
  parameter int unsigned RAW   = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_req_i,
  input  logic            reg_we_i,
  input  logic [RAW-1:0]  reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  output logic            irq_o,
  output logic            xreq_valid_o,
  input  logic            xreq_ready_i,
  output logic [ID_W-1:0] xreq_id_o,
  output logic [AW-1:0]   xreq_dst_o,
  output logic [AW-1:0]   xreq_src_o,
  output logic [LW-1:0]   xreq_len_o,
  input  logic            xdone_valid_i,
  input  logic [ID_W-1:0] xdone_id_i,
  output logic            abort_o
);
  import dmaq_pkg::*;

  localparam int unsigned NID = 2 ** ID_W;

  typedef struct packed {
    logic [AW-1:0] dst;
    logic [AW-1:0] src;
    logic [LW-1:0] len;
  } parm_t;

  typedef struct packed {
    logic [ID_W-1:0] id;
    parm_t           p;
  } ent_t;

  localparam int unsigned EW = $bits(ent_t);

  logic            en_q, pause_q, busy_q, abort_q, sub_pend_q;
  logic [ID_W-1:0] act_id_q;
  parm_t           parm_q, sub_parm_q;

  logic            wr, ctrl_wr, stop, submit_wr, push, pop;
  logic            fifo_empty, fifo_full;
  logic [EW-1:0]   head_bits;
  ent_t            head, push_ent;
  logic [ID_W-1:0] next_id;
  logic [NID-1:0]  done_map;
  logic [EV_N-1:0] ev_set, mask, pend, src;

  assign wr        = reg_req_i && reg_we_i;
  assign ctrl_wr   = wr && (12'(reg_addr_i) == OFS_CTRL);
  assign stop      = ctrl_wr && !reg_wdata_i[0];
  assign submit_wr = wr && (12'(reg_addr_i) == OFS_SUBMIT) && reg_wdata_i[0]
                     && en_q && !sub_pend_q;
  assign push      = sub_pend_q && !fifo_full && !stop;
  assign head      = ent_t'(head_bits);
  assign xreq_valid_o = !fifo_empty && en_q && !pause_q && !busy_q;
  assign pop       = xreq_valid_o && xreq_ready_i;

  assign xreq_id_o  = head.id;
  assign xreq_dst_o = head.p.dst;
  assign xreq_src_o = head.p.src;
  assign xreq_len_o = head.p.len;
  assign abort_o    = abort_q;

  always_comb begin
    push_ent.id = next_id;
    push_ent.p  = sub_parm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      pause_q <= 1'b0;
      abort_q <= 1'b0;
      parm_q  <= '0;
    end else begin
      abort_q <= stop && en_q;
      if (ctrl_wr) begin
        en_q    <= reg_wdata_i[0];
        pause_q <= reg_wdata_i[1];
      end
      if (wr && 12'(reg_addr_i) == OFS_DST) parm_q.dst <= AW'(reg_wdata_i);
      if (wr && 12'(reg_addr_i) == OFS_SRC) parm_q.src <= AW'(reg_wdata_i);
      if (wr && 12'(reg_addr_i) == OFS_LEN) parm_q.len <= LW'(reg_wdata_i);
    end
  end

  // submission parked until a slot frees; parameters snapshot at submit time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_pend_q <= 1'b0;
      sub_parm_q <= '0;
    end else if (stop) begin
      sub_pend_q <= 1'b0;
    end else if (submit_wr) begin
      sub_pend_q <= 1'b1;
      sub_parm_q <= parm_q;
    end else if (push) begin
      sub_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      act_id_q <= '0;
    end else if (stop) begin
      busy_q <= 1'b0;
    end else if (pop) begin
      busy_q   <= 1'b1;
      act_id_q <= head.id;
    end else if (xdone_valid_i && xdone_id_i == act_id_q) begin
      busy_q <= 1'b0;
    end
  end

  dmaq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (stop),
    .push_i  (push),
    .data_i  (EW'(push_ent)),
    .pop_i   (pop),
    .data_o  (head_bits),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  dmaq_ids #(.ID_W(ID_W)) u_ids (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (push),
    .done_valid_i (xdone_valid_i),
    .done_id_i    (xdone_id_i),
    .next_id_o    (next_id),
    .done_map_o   (done_map)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_SLOT] = pop;
    ev_set[EV_DONE] = xdone_valid_i;
  end

  dmaq_irq #(.N(EV_N)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ev_set),
    .clr_wr_i  (wr && 12'(reg_addr_i) == OFS_PEND),
    .clr_i     (reg_wdata_i[EV_N-1:0]),
    .mask_wr_i (wr && 12'(reg_addr_i) == OFS_MASK),
    .mask_i    (reg_wdata_i[EV_N-1:0]),
    .mask_o    (mask),
    .pend_o    (pend),
    .src_o     (src),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (12'(reg_addr_i))
      OFS_MASK:    reg_rdata_o = 32'(mask);
      OFS_PEND:    reg_rdata_o = 32'(pend);
      OFS_SOURCE:  reg_rdata_o = 32'(src);
      OFS_CTRL:    reg_rdata_o = {30'd0, pause_q, en_q};
      OFS_NEXT_ID: reg_rdata_o = 32'(next_id);
      OFS_SUBMIT:  reg_rdata_o = {31'd0, sub_pend_q};
      OFS_DST:     reg_rdata_o = 32'(parm_q.dst);
      OFS_SRC:     reg_rdata_o = 32'(parm_q.src);
      OFS_LEN:     reg_rdata_o = 32'(parm_q.len);
      OFS_DONE:    reg_rdata_o = 32'(done_map);
      OFS_ACTIVE:  reg_rdata_o = 32'(act_id_q);
      default:     reg_rdata_o = '0;
    endcase
  end

  AST_SUBMIT_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_pend_q && fifo_full && !pop && !stop) |=> sub_pend_q); // R3
  AST_OFFER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xreq_valid_o && !xreq_ready_i && !ctrl_wr) |=> (xreq_valid_o && $stable(xreq_id_o))); // R4
  AST_ABORT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (!xreq_valid_o && !sub_pend_q)); // R10
  AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_q && !xreq_valid_o && !ctrl_wr) |=> !xreq_valid_o); // R9
endmodule

// File: tb/dmaq_ctrl_test.sv
`timescale 1ns/100ps
module dmaq_ctrl_test;
  import dmaq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, xreq_valid_o, abort_o;
  logic        xreq_ready_i = 1'b0;
  logic [2:0]  xreq_id_o;
  logic [31:0] xreq_dst_o, xreq_src_o;
  logic [23:0] xreq_len_o;
  logic        xdone_valid_i = 1'b0;
  logic [2:0]  xdone_id_i = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  typedef struct {
    logic [2:0]  id;
    logic [31:0] dst;
    logic [31:0] src;
    logic [23:0] len;
  } exp_t;
  exp_t exp_q[$];
  logic [2:0] exp_id = '0;

  always #2 clk = ~clk;

  dmaq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_req_i(reg_req_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .xreq_valid_o(xreq_valid_o), .xreq_ready_i(xreq_ready_i), .xreq_id_o(xreq_id_o),
    .xreq_dst_o(xreq_dst_o), .xreq_src_o(xreq_src_o), .xreq_len_o(xreq_len_o),
    .xdone_valid_i(xdone_valid_i), .xdone_id_i(xdone_id_i), .abort_o(abort_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_req_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_req_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_req_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
    reg_req_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  // driver: wait for a free submit, confirm the tag, program and submit
  task automatic submit(input logic [31:0] dst, input logic [31:0] src, input logic [23:0] len);
    logic [31:0] v;
    exp_t e;
    for (int i = 0; i < 50; i++) begin
      rd(OFS_SUBMIT, v);
      if (v == 0) break;
      tick();
    end
    rd_chk("R2 next tag", OFS_NEXT_ID, 32'(exp_id));
    wr(OFS_DST, dst);
    wr(OFS_SRC, src);
    wr(OFS_LEN, 32'(len));
    wr(OFS_SUBMIT, 32'd1);
    e.id = exp_id; e.dst = dst; e.src = src; e.len = len;
    exp_q.push_back(e);
    exp_id = exp_id + 3'd1;
  endtask

  task automatic complete(input logic [2:0] id);
    xdone_valid_i = 1'b1; xdone_id_i = id;
    tick();
    xdone_valid_i = 1'b0;
  endtask

  // monitor: every handshake is compared against the scoreboard head (R4)
  always @(negedge clk) begin
    if (rst_ni && xreq_valid_o && xreq_ready_i) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R4 unexpected request: got %0h expected none", xreq_id_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R4 req tag", 32'(xreq_id_o), 32'(e.id));
        chk("R2 req dst", xreq_dst_o, e.dst);
        chk("R2 req src", xreq_src_o, e.src);
        chk("R2 req len", 32'(xreq_len_o), 32'(e.len));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected below 20000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    rd_chk("R1 ctrl", OFS_CTRL, 0);
    rd_chk("R1 mask", OFS_MASK, 3);
    rd_chk("R1 pend", OFS_PEND, 0);
    rd_chk("R1 next", OFS_NEXT_ID, 0);
    rd_chk("R1 done", OFS_DONE, 0);
    rd_chk("R1 submit", OFS_SUBMIT, 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 valid", 32'(xreq_valid_o), 0);

    wr(OFS_MASK, 0);
    wr(OFS_CTRL, 1);
    xreq_ready_i = 1'b1;
    submit(32'h1000, 32'h2000, 24'd64);
    repeat (4) tick();
    rd_chk("R5 active", OFS_ACTIVE, 0);
    rd_chk("R7 slot event", OFS_PEND, 1);
    chk("R8 irq on slot", 32'(irq_o), 1);
    wr(OFS_PEND, 1);
    rd_chk("R7 w1c", OFS_PEND, 0);
    chk("R8 irq cleared", 32'(irq_o), 0);
    complete(3'd0);
    rd_chk("R6 done bit0", OFS_DONE, 32'h01);
    rd_chk("R7 done event", OFS_PEND, 2);
    wr(OFS_PEND, 2);

    // R3 fill the queue with the engine stalled
    xreq_ready_i = 1'b0;
    submit(32'h1100, 32'h2100, 24'd16);
    submit(32'h1200, 32'h2200, 24'd32);
    submit(32'h1300, 32'h2300, 24'd48);
    submit(32'h1400, 32'h2400, 24'd80);
    repeat (2) tick();
    submit(32'h1500, 32'h2500, 24'd96);
    repeat (3) tick();
    rd_chk("R3 submit busy", OFS_SUBMIT, 1);
    rd_chk("R3 tag held", OFS_NEXT_ID, 5);
    wr(OFS_SRC, 32'hDEAD);
    wr(OFS_SUBMIT, 1);       // ignored while waiting
    tick();
    rd_chk("R3 still busy", OFS_SUBMIT, 1);
    chk("R4 offer held", 32'(xreq_valid_o), 1);
    chk("R4 offer tag", 32'(xreq_id_o), 1);

    // R9 pause before handout
    wr(OFS_CTRL, 3);
    xreq_ready_i = 1'b1;
    repeat (3) tick();
    chk("R9 paused no offer", 32'(xreq_valid_o), 0);
    rd_chk("R9 active unchanged", OFS_ACTIVE, 0);
    wr(OFS_CTRL, 1);
    repeat (3) tick();
    rd_chk("R5 active 1", OFS_ACTIVE, 1);
    rd_chk("R3 slot freed", OFS_SUBMIT, 0);
    // R9 pause with a transfer in flight
    wr(OFS_CTRL, 3);
    complete(3'd1);
    repeat (3) tick();
    rd_chk("R9 in-flight finished", OFS_DONE, 32'h03);
    chk("R9 no new offer", 32'(xreq_valid_o), 0);
    wr(OFS_CTRL, 1);
    for (int k = 2; k <= 5; k++) begin
      repeat (3) tick();
      complete(3'(k));
    end
    rd_chk("R6 done map", OFS_DONE, 32'h3F);

    // R2 tag wrap and R6 reissue clear
    submit(32'h1600, 32'h2600, 24'd8);
    repeat (3) tick();
    complete(3'd6);
    submit(32'h1700, 32'h2700, 24'd8);
    repeat (3) tick();
    complete(3'd7);
    rd_chk("R6 all done", OFS_DONE, 32'hFF);
    submit(32'h1800, 32'h2800, 24'd8);
    repeat (3) tick();
    rd_chk("R6 reissue clears", OFS_DONE, 32'hFE);
    rd_chk("R2 wrap", OFS_NEXT_ID, 1);
    complete(3'd0);

    // R8 mask
    wr(OFS_PEND, 3);
    wr(OFS_MASK, 1);
    submit(32'h1900, 32'h2900, 24'd4);
    repeat (3) tick();
    rd_chk("R7 latch under mask", OFS_PEND, 1);
    rd_chk("R8 source masked", OFS_SOURCE, 0);
    chk("R8 irq masked", 32'(irq_o), 0);
    complete(3'd1);
    rd_chk("R8 source done", OFS_SOURCE, 2);
    chk("R8 irq done", 32'(irq_o), 1);
    wr(OFS_MASK, 3);
    chk("R8 all masked", 32'(irq_o), 0);
    wr(OFS_MASK, 0);

    // R10 abort
    xreq_ready_i = 1'b0;
    submit(32'h1A00, 32'h2A00, 24'd4);
    submit(32'h1B00, 32'h2B00, 24'd4);
    repeat (2) tick();
    wr(OFS_CTRL, 0);
    chk("R10 abort pulse", 32'(abort_o), 1);
    tick();
    chk("R10 abort one cycle", 32'(abort_o), 0);
    exp_q.delete();
    rd_chk("R10 submit clear", OFS_SUBMIT, 0);
    wr(OFS_SUBMIT, 1);       // ignored while disabled
    tick();
    rd_chk("R10 no tag while disabled", OFS_NEXT_ID, 4);
    wr(OFS_CTRL, 1);
    xreq_ready_i = 1'b1;
    repeat (4) tick();
    chk("R10 queue flushed", 32'(xreq_valid_o), 0);
    submit(32'h1C00, 32'h2C00, 24'd12);
    repeat (3) tick();
    rd_chk("R5 active after abort", OFS_ACTIVE, 4);
    complete(3'd4);
    repeat (2) tick();
    chk("R4 scoreboard drained", 32'(exp_q.size()), 0);

    summary();
    $finish;
  end
endmodule